// File: doc/BRIEF.md
# Set/Clear/Toggle Control Register Bank

A bank of 32-bit control registers on a simple single-cycle memory-mapped bus. Each register owns a 16-byte address window. The window holds four word aliases, and the alias used for a write decides how the stored value changes. The value can be replaced, have bits ORed in, have bits cleared, or have bits inverted. Software can then change single control bits without a read-modify-write sequence.

Reads are registered, with one cycle of latency. A read at any alias of a register returns that register's current value. A write that uses a malformed offset or an index past the last register has no effect, and it raises an error pulse. A read-only mask input freezes selected registers against every kind of write.

Top module: `sct_reg_bank`

## Requirements
- R1: After reset every register reads as zero, and `rdata_o` and `err_o` are both 0.
- R2: A write with `addr_i[3:0]` = 0x0 replaces register `addr_i[ADDR_W-1:4]` with `wdata_i`.
- R3: A write with `addr_i[3:0]` = 0x4 sets the register to its old value OR `wdata_i`.
- R4: A write with `addr_i[3:0]` = 0x8 sets the register to its old value AND NOT `wdata_i`.
- R5: A write with `addr_i[3:0]` = 0xC sets the register to its old value XOR `wdata_i`.
- R6: In every cycle, `rdata_o` on the following cycle shows the value stored before that cycle's edge at index `addr_i[ADDR_W-1:4]`, whatever the low nibble is. A write becomes visible to a read issued in the next cycle.
- R7: A write whose `addr_i[1:0]` is not 0 changes no register. `err_o` is 1 in the following cycle only.
- R8: A write to an index of NUM_REGS or more changes nothing and raises `err_o` in the following cycle. A read at such an index returns zero.
- R9: A register whose `ro_mask_i` bit is 1 is left unchanged by all four write kinds, and no error is raised.
- R10: `err_o` is 0 in the cycle after any cycle that has no write, and in the cycle after a well-formed in-range write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address: the index is in bits [ADDR_W-1:4] and the operation alias in bits [3:0] |
| we_i | input | 1 | Write strobe for this cycle |
| wdata_i | input | DATA_W | Write operand |
| ro_mask_i | input | NUM_REGS | One bit per register; 1 blocks writes |
| rdata_o | output | DATA_W | Registered read data |
| err_o | output | 1 | One-cycle pulse after a rejected write |

## Verification
The hardest case to reach is a modify operation that hits a register in the cycle right after another write to the same register. The new write must build on the value the previous write just stored. In that same cycle, `rdata_o` must still return the value from before the current write. The stimulus reaches this by issuing runs of back-to-back set, clear and toggle writes to one index. A software model in the bench works out the stored value and the read data separately for every cycle. Frozen registers are covered by changing the read-only mask between operations and then reading the frozen register back through each alias.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int unsigned NIB_W = 4;

  typedef enum logic [1:0] {
    SCT_WR  = 2'd0,
    SCT_SET = 2'd1,
    SCT_CLR = 2'd2,
    SCT_TOG = 2'd3
  } sct_op_e;
endpackage

// File: rtl/sct_addr_decode.sv
module sct_addr_decode
  import sct_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned IDX_W   = ADDR_W - NIB_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output sct_op_e           op_o,
  output logic              nib_ok_o,
  output logic              in_range_o
);
  assign idx_o      = addr_i[ADDR_W-1:NIB_W];
  assign op_o       = sct_op_e'(addr_i[3:2]);
  assign nib_ok_o   = (addr_i[1:0] == 2'b00);
  assign in_range_o = (32'(idx_o) < NUM_REGS);
endmodule

// File: rtl/sct_reg_slice.sv
module sct_reg_slice
  import sct_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  sct_op_e           op_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else if (wr_en_i) begin
      unique case (op_i)
        SCT_WR:  q_o <= wdata_i;
        SCT_SET: q_o <= q_o | wdata_i;
        SCT_CLR: q_o <= q_o & ~wdata_i;
        SCT_TOG: q_o <= q_o ^ wdata_i;
        default: q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/sct_read_mux.sv
module sct_read_mux #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned IDX_W    = 4
) (
  input  logic [DATA_W-1:0] regs_i [NUM_REGS],
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              in_range_i,
  output logic [DATA_W-1:0] rdata_o
);
  // one-hot AND-OR select; zero when out of range
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (in_range_i && (idx_i == IDX_W'(i))) rdata_o = rdata_o | regs_i[i];
    end
  end
endmodule

// File: rtl/sct_reg_bank.sv
module sct_reg_bank
  import sct_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned ADDR_W   = 8,
  localparam int unsigned IDX_W   = ADDR_W - NIB_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [NUM_REGS-1:0] ro_mask_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                err_o
);
  logic [IDX_W-1:0]  idx;
  sct_op_e           op;
  logic              nib_ok;
  logic              in_range;
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] rd_mux;

  sct_addr_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_REGS(NUM_REGS)
  ) u_dec (
    .addr_i    (addr_i),
    .idx_o     (idx),
    .op_o      (op),
    .nib_ok_o  (nib_ok),
    .in_range_o(in_range)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = we_i && nib_ok && in_range && (idx == IDX_W'(g)) && !ro_mask_i[g];
    sct_reg_slice #(
      .DATA_W(DATA_W)
    ) u_slice (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_en_i(hit),
      .op_i   (op),
      .wdata_i(wdata_i),
      .q_o    (regs[g])
    );
  end

  sct_read_mux #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W)
  ) u_rmux (
    .regs_i    (regs),
    .idx_i     (idx),
    .in_range_i(in_range),
    .rdata_o   (rd_mux)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= rd_mux;
      err_o   <= we_i && !(nib_ok && in_range);
    end
  end
endmodule

// File: rtl/sct_reg_bank_chk.sv
module sct_reg_bank_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned ADDR_W   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o
);
  logic in_rng;
  assign in_rng = (32'(addr_i[ADDR_W-1:4]) < NUM_REGS);

  p_err_needs_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(we_i));

  p_bad_nibble_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i[1:0] != 2'b00)) |=> err_o);

  p_oor_write_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !in_rng) |=> err_o);

  p_oor_read_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_rng |=> (rdata_o == '0));

  p_good_write_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i[1:0] == 2'b00) && in_rng) |=> !err_o);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> !err_o);

  p_read_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(we_i) && (addr_i[ADDR_W-1:4] == $past(addr_i[ADDR_W-1:4])))
      |=> $stable(rdata_o));
endmodule

bind sct_reg_bank sct_reg_bank_chk #(
  .DATA_W  (DATA_W),
  .NUM_REGS(NUM_REGS),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .we_i   (we_i),
  .rdata_o(rdata_o),
  .err_o  (err_o)
);

// File: tb/tb_sct_reg_bank.sv
module tb_sct_reg_bank;
  localparam int unsigned DW = 32;
  localparam int unsigned NR = 8;
  localparam int unsigned AW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          we_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic [NR-1:0] ro_mask_i = '0;
  logic [DW-1:0] rdata_o;
  logic          err_o;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] model [NR];
  logic [NR-1:0] ro_next = '0;
  logic [DW-1:0] q_rd [$];
  bit            q_er [$];
  string         q_tag [$];

  always #5 clk_i = ~clk_i;

  sct_reg_bank #(.DATA_W(DW), .NUM_REGS(NR), .ADDR_W(AW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .ro_mask_i(ro_mask_i), .rdata_o(rdata_o), .err_o(err_o)
  );

  // driver: one bus cycle, pushes expected result for the following edge
  task automatic bus(input logic [AW-1:0] a, input bit w, input logic [DW-1:0] d,
                     input string tag);
    int  idx;
    bit  inr;
    logic [DW-1:0] old;
    @(negedge clk_i);
    addr_i = a; we_i = w; wdata_i = d; ro_mask_i = ro_next;
    idx = int'(a[AW-1:4]);
    inr = idx < NR;
    old = inr ? model[idx] : '0;
    q_rd.push_back(old);
    q_er.push_back(w && !(inr && a[1:0] == 2'b00));
    q_tag.push_back(tag);
    if (w && inr && a[1:0] == 2'b00 && !ro_next[idx]) begin
      case (a[3:2])
        2'd0: model[idx] = d;
        2'd1: model[idx] = old | d;
        2'd2: model[idx] = old & ~d;
        default: model[idx] = old ^ d;
      endcase
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    bus(a, 1'b0, '0, tag);
  endtask

  // monitor: compares after each active edge
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (rst_ni && q_rd.size() > 0) begin
        logic [DW-1:0] er_d;
        bit            er_e;
        string         t;
        er_d = q_rd.pop_front();
        er_e = q_er.pop_front();
        t    = q_tag.pop_front();
        checks++;
        if (rdata_o !== er_d || err_o !== er_e) begin
          errors++;
          $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                   t, rdata_o, err_o, er_d, er_e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    checks++;
    if (rdata_o !== '0 || err_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: rdata=%h err=%b expected rdata=0 err=0", rdata_o, err_o);
    end
    // R1: every register zero after reset
    for (int i = 0; i < NR; i++) rd(AW'(i << 4), "R1");
    // R2: plain writes, then readback
    for (int i = 0; i < NR; i++) bus(AW'(i << 4), 1'b1, DW'(32'h0101_0101 * (i + 1)) ^ 32'h5A00_0000, "R2");
    for (int i = 0; i < NR; i++) rd(AW'(i << 4), "R2");
    // R3/R4/R5 on register 2 with alias reads (R6)
    bus(8'h24, 1'b1, 32'h0000_F0F0, "R3");
    rd(8'h28, "R3");
    bus(8'h28, 1'b1, 32'h0F00_00F0, "R4");
    rd(8'h2C, "R4");
    bus(8'h2C, 1'b1, 32'hFFFF_0000, "R5");
    rd(8'h20, "R6");
    rd(8'h24, "R6");
    rd(8'h28, "R6");
    rd(8'h2C, "R6");
    // R6: back-to-back modifies of one register
    bus(8'h30, 1'b1, 32'h1234_5678, "R2");
    bus(8'h34, 1'b1, 32'h8000_0001, "R3");
    bus(8'h3C, 1'b1, 32'hFFFF_FFFF, "R5");
    bus(8'h38, 1'b1, 32'h0000_FFFF, "R4");
    bus(8'h3C, 1'b1, 32'h00FF_00FF, "R6");
    rd(8'h30, "R6");
    // R7: malformed low nibble
    bus(8'h22, 1'b1, 32'hDEAD_BEEF, "R7");
    bus(8'h26, 1'b1, 32'hDEAD_BEEF, "R7");
    bus(8'h2F, 1'b1, 32'hDEAD_BEEF, "R7");
    rd(8'h20, "R7");
    bus(8'h21, 1'b1, 32'h0000_0000, "R7");
    rd(8'h20, "R7");
    // R8: out-of-range index
    bus(8'h80, 1'b1, 32'hCAFE_F00D, "R8");
    bus(8'h94, 1'b1, 32'hCAFE_F00D, "R8");
    bus(8'hFC, 1'b1, 32'hCAFE_F00D, "R8");
    rd(8'h80, "R8");
    rd(8'hF0, "R8");
    for (int i = 0; i < NR; i++) rd(AW'(i << 4), "R8");
    // R9: read-only register 5
    ro_next = 8'h20;
    bus(8'h50, 1'b1, 32'h0000_0000, "R9");
    bus(8'h54, 1'b1, 32'hFFFF_FFFF, "R9");
    bus(8'h58, 1'b1, 32'hFFFF_FFFF, "R9");
    bus(8'h5C, 1'b1, 32'hFFFF_FFFF, "R9");
    rd(8'h50, "R9");
    bus(8'h40, 1'b1, 32'hA5A5_A5A5, "R9");
    rd(8'h40, "R9");
    ro_next = 8'h00;
    bus(8'h5C, 1'b1, 32'h0F0F_0F0F, "R9");
    rd(8'h54, "R9");
    // R10: idle cycles and good writes stay quiet
    rd(8'h70, "R10");
    bus(8'h74, 1'b1, 32'h0000_0010, "R10");
    rd(8'h70, "R10");
    repeat (3) @(posedge clk_i);
    #2;
    checks++;
    if (q_rd.size() != 0) begin
      errors++;
      $display("FAIL R6: pending=%0d expected=0", q_rd.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule